// File: doc/BRIEF.md
# Execute-Packet Dispatcher for an Eight-Lane Issue Stage

This block sits between the instruction memory and the decode stage of a wide-issue core. It takes in fetch packets of 256 bits, each made of eight 32-bit instruction slots. It cuts them into execute packets by following the chaining bit in bit 0 of each slot. Each execute packet leaves on an eight-lane issue port in a single cycle. The instruction words are packed into the low lanes, and a valid mask marks the lanes in use.

Code is not padded. An execute packet may start near the end of one fetch packet and end early in the next. The dispatcher keeps the chained tail of the old packet in a holding register and fetches the next packet. It then joins the two parts and issues the merged packet in one cycle. The dispatcher requests a new fetch packet only after it has used up every slot of the current one. A packet that would grow past eight instructions is cut at eight, and a flag marks the cut. A flush input drops everything held inside the block.

Top module: `edp_dispatch`

## Requirements
- R1: While reset is low and in the first cycle after it, `issue_valid` is 0 and `fetch_ready` is 1.
- R2: `fetch_ready` is 1 exactly when no slot of the current fetch packet is left to dispatch and `flush` is low. A fetch packet is taken on a cycle where `fetch_valid` and `fetch_ready` are both 1. `fetch_ready` and `issue_valid` are never 1 together.
- R3: Slot k of a fetch packet is `fetch_data[32k+31:32k]`, and slot 0 comes first in program order. An execute packet runs to the first slot whose bit 0 is 0, and includes that slot. The next slot starts a new execute packet.
- R4: An issued packet of n instructions puts its words in lanes 0..n-1 in program order. Lane i is `issue_words[32i+31:32i]`. `issue_mask` has bits 0..n-1 set, and the unused lanes read zero.
- R5: When the current fetch packet holds several whole execute packets and `issue_ready` is high, one execute packet is issued per cycle, with no gap between them.
- R6: When the last slot of a fetch packet has bit 0 set to 1, nothing is issued for that tail. The tail is held, and the next fetch packet is requested. The held words and the leading slots of the new packet leave together as one packet in one cycle.
- R7: A chain that reaches eight instructions without a terminating slot is issued as eight instructions with `issue_overlen` set. The slot after the cut starts a new packet.
- R8: While `issue_valid` is 1 and `issue_ready` is 0, the packet on the issue port stays unchanged in the next cycle, unless `flush` is asserted.
- R9: `flush` discards the rest of the current fetch packet and any held partial packet. In the cycle after a flush, with `flush` low, `fetch_ready` is 1. No discarded word is ever issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| flush | input | 1 | Discard all held instruction state |
| fetch_valid | input | 1 | Instruction memory presents a fetch packet |
| fetch_ready | output | 1 | Dispatcher can accept a fetch packet |
| fetch_data | input | 256 | Fetch packet, slot k in bits 32k+31:32k |
| issue_valid | output | 1 | An execute packet is on the issue port |
| issue_ready | input | 1 | Decode stage accepts the execute packet |
| issue_mask | output | 8 | Lanes in use, packed from lane 0 |
| issue_words | output | 256 | Instruction words, lane i in bits 32i+31:32i |
| issue_overlen | output | 1 | Packet was cut at eight instructions |

## Verification
The hardest case to reach from the ports is a held tail that runs into a chain that is cut at eight. The cut leaves a new chained tail, which must then be held again. Fixed chain patterns set up this double spanning on purpose. Long random runs then cover all the other cases: random chain bits, random gaps in `fetch_valid`, random backpressure on `issue_ready`, and flushes that land while a partial packet is held. A behavioural model built from queues of words predicts both handshakes and the issue port on every cycle.

// File: rtl/edp_pkg.sv
package edp_pkg;
  // What the dispatcher does with the words at the read pointer
  typedef enum logic [1:0] {
    STEP_ISSUE = 2'd0,  // terminating slot found within budget
    STEP_CUT   = 2'd1,  // budget filled with chained slots
    STEP_CARRY = 2'd2   // fetch packet ran out while chaining
  } step_e;
endpackage

// File: rtl/edp_boundary_scan.sv
module edp_boundary_scan #(
  parameter int LANES = 8,
  localparam int CW = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0] chain,
  input  logic [CW-1:0]    ptr,
  input  logic [CW-1:0]    carry,
  output edp_pkg::step_e   step,
  output logic [CW-1:0]    take
);
  // Lanes still free once the held words are placed
  function automatic int budget_of(input int held);
    return LANES - held;
  endfunction

  always_comb begin
    int p;
    int b;
    int t;
    logic found;
    logic [LANES-1:0] sh;
    p = int'(ptr);
    b = budget_of(int'(carry));
    sh = chain >> p;
    t = 0;
    found = 1'b0;
    for (int j = 0; j < LANES; j++) begin
      if (!found && j < b && j < LANES - p) begin
        t = j + 1;
        found = !sh[j];
      end
    end
    if (found)
      step = edp_pkg::STEP_ISSUE;
    else if (p + b <= LANES)
      step = edp_pkg::STEP_CUT;
    else
      step = edp_pkg::STEP_CARRY;
    take = CW'(t);
  end
endmodule

// File: rtl/edp_lane_pack.sv
module edp_lane_pack #(
  parameter int LANES = 8,
  parameter int IW = 32,
  localparam int CW = $clog2(LANES + 1),
  localparam int PW = LANES * IW
) (
  input  logic [PW-1:0]    bufv,
  input  logic [PW-1:0]    carryv,
  input  logic [CW-1:0]    ptr,
  input  logic [CW-1:0]    carry,
  input  logic [CW-1:0]    take,
  output logic [PW-1:0]    lanes,
  output logic [LANES-1:0] mask
);
  function automatic logic [PW-1:0] word_mask(input int n);
    logic [PW-1:0] m;
    m = '0;
    for (int i = 0; i < LANES; i++)
      if (i < n) m[i*IW +: IW] = '1;
    return m;
  endfunction

  function automatic logic [LANES-1:0] lane_mask(input int n);
    logic [LANES-1:0] m;
    for (int i = 0; i < LANES; i++) m[i] = (i < n);
    return m;
  endfunction

  always_comb begin
    int c;
    int t;
    int p;
    c = int'(carry);
    t = int'(take);
    p = int'(ptr);
    // held words stay in the low lanes; fresh slots slide in after them
    lanes = (carryv & word_mask(c)) |
            (((bufv >> (p * IW)) << (c * IW)) & word_mask(c + t));
    mask  = lane_mask(c + t);
  end
endmodule

// File: rtl/edp_dispatch.sv
module edp_dispatch #(
  parameter int LANES = 8,
  parameter int IW = 32,
  localparam int CW = $clog2(LANES + 1),
  localparam int PW = LANES * IW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             fetch_valid,
  output logic             fetch_ready,
  input  logic [PW-1:0]    fetch_data,
  output logic             issue_valid,
  input  logic             issue_ready,
  output logic [LANES-1:0] issue_mask,
  output logic [PW-1:0]    issue_words,
  output logic             issue_overlen
);
  logic            have_q;
  logic [CW-1:0]   ptr_q;
  logic [CW-1:0]   carry_q;
  logic [PW-1:0]   bufv_q;
  logic [PW-1:0]   carryv_q;

  logic [LANES-1:0] chain_bits;
  edp_pkg::step_e   step;
  logic [CW-1:0]    take;
  logic [PW-1:0]    lanes;
  logic [LANES-1:0] lmask;
  logic [CW-1:0]    next_ptr;

  // named events, used by the bound checker
  logic ev_fetch;
  logic ev_issue;
  logic ev_carry;
  logic ev_last;

  for (genvar g = 0; g < LANES; g++) begin : g_chain
    assign chain_bits[g] = bufv_q[g*IW];
  end

  edp_boundary_scan #(.LANES(LANES)) u_scan (
    .chain (chain_bits),
    .ptr   (ptr_q),
    .carry (carry_q),
    .step  (step),
    .take  (take)
  );

  edp_lane_pack #(.LANES(LANES), .IW(IW)) u_pack (
    .bufv   (bufv_q),
    .carryv (carryv_q),
    .ptr    (ptr_q),
    .carry  (carry_q),
    .take   (take),
    .lanes  (lanes),
    .mask   (lmask)
  );

  assign fetch_ready   = !have_q && !flush;
  assign issue_valid   = have_q && !flush && (step != edp_pkg::STEP_CARRY);
  assign issue_mask    = issue_valid ? lmask : '0;
  assign issue_words   = lanes;
  assign issue_overlen = issue_valid && (step == edp_pkg::STEP_CUT);

  assign next_ptr = ptr_q + take;
  assign ev_fetch = fetch_valid && fetch_ready;
  assign ev_issue = issue_valid && issue_ready;
  assign ev_carry = have_q && !flush && (step == edp_pkg::STEP_CARRY);
  assign ev_last  = ev_issue && (next_ptr == CW'(LANES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_q   <= 1'b0;
      ptr_q    <= '0;
      carry_q  <= '0;
      bufv_q   <= '0;
      carryv_q <= '0;
    end else if (flush) begin
      have_q  <= 1'b0;
      ptr_q   <= '0;
      carry_q <= '0;
    end else if (ev_fetch) begin
      bufv_q <= fetch_data;
      ptr_q  <= '0;
      have_q <= 1'b1;
    end else if (ev_carry) begin
      carryv_q <= lanes;
      carry_q  <= carry_q + take;
      ptr_q    <= '0;
      have_q   <= 1'b0;
    end else if (ev_issue) begin
      carry_q <= '0;
      if (ev_last) begin
        have_q <= 1'b0;
        ptr_q  <= '0;
      end else begin
        ptr_q <= next_ptr;
      end
    end
  end
endmodule

// File: rtl/edp_dispatch_checker.sv
module edp_dispatch_checker #(
  parameter int LANES = 8,
  parameter int IW = 32,
  localparam int PW = LANES * IW
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             fetch_ready,
  input logic             issue_valid,
  input logic             issue_ready,
  input logic [LANES-1:0] issue_mask,
  input logic [PW-1:0]    issue_words,
  input logic             issue_overlen,
  input logic             ev_carry
);
  // chain bits of the issued lanes must agree with how the packet ended
  function automatic logic chain_consistent(input logic [LANES-1:0] m,
                                            input logic [PW-1:0] w,
                                            input logic cut);
    logic ok;
    logic last;
    ok = 1'b1;
    for (int i = 0; i < LANES; i++) begin
      if (m[i]) begin
        last = ((m >> (i + 1)) == '0);
        if (!last && !w[i*IW]) ok = 1'b0;
        if (last && (w[i*IW] != cut)) ok = 1'b0;
      end
    end
    return ok;
  endfunction

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> !issue_valid);

  assert_fetch_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_ready && issue_valid));

  assert_chain_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> chain_consistent(issue_mask, issue_words, issue_overlen));

  assert_mask_packed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> (issue_mask != '0) &&
                    ((issue_mask & (issue_mask + 1'b1)) == '0));

  assert_carry_refetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_carry |=> (fetch_ready || flush));

  assert_cut_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_overlen) |-> (&issue_mask));

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !issue_ready && !flush) |=>
      (flush || (issue_valid && $stable(issue_mask) &&
                 $stable(issue_words) && $stable(issue_overlen))));

  assert_flush_refetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (flush || fetch_ready));
endmodule

bind edp_dispatch edp_dispatch_checker #(.LANES(LANES), .IW(IW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .flush         (flush),
  .fetch_ready   (fetch_ready),
  .issue_valid   (issue_valid),
  .issue_ready   (issue_ready),
  .issue_mask    (issue_mask),
  .issue_words   (issue_words),
  .issue_overlen (issue_overlen),
  .ev_carry      (ev_carry)
);

// File: tb/test_edp_dispatch.sv
`timescale 1ns/1ps
module test_edp_dispatch;
  localparam int LANES = 8;
  localparam int IW = 32;
  localparam int PW = LANES * IW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n;
  logic             flush;
  logic             fetch_valid;
  logic             fetch_ready;
  logic [PW-1:0]    fetch_data;
  logic             issue_valid;
  logic             issue_ready;
  logic [LANES-1:0] issue_mask;
  logic [PW-1:0]    issue_words;
  logic             issue_overlen;

  edp_dispatch #(.LANES(LANES), .IW(IW)) i_edp_dispatch (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_data(fetch_data),
    .issue_valid(issue_valid), .issue_ready(issue_ready), .issue_mask(issue_mask),
    .issue_words(issue_words), .issue_overlen(issue_overlen)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int serial = 1;
  int rdy_pct = 100;
  int val_pct = 100;
  int flush_pct = 0;
  bit prev_stall = 0;

  logic [IW-1:0] cur[$];
  logic [IW-1:0] part[$];
  logic [PW-1:0] supply[$];

  task automatic chk(input string req, input string what,
                     input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // chain bit k goes to slot k; the rest of each word is a running serial
  function automatic logic [PW-1:0] make_pkt(input logic [LANES-1:0] chains);
    logic [PW-1:0] v;
    for (int k = 0; k < LANES; k++) begin
      v[k*IW +: IW] = {serial[IW-2:0], chains[k]};
      serial++;
    end
    return v;
  endfunction

  task automatic step_cycle();
    logic [IW-1:0] tmp[$];
    logic [PW-1:0] exp_w;
    int idx;
    bit term;
    bit exp_fr;
    bit exp_iv;
    bit exp_ov;
    string tag;
    @(negedge clk);
    flush       = ($urandom_range(99) < flush_pct);
    issue_ready = ($urandom_range(99) < rdy_pct);
    fetch_valid = (supply.size() > 0) && ($urandom_range(99) < val_pct);
    fetch_data  = (supply.size() > 0) ? supply[0] : '0;
    #1;
    exp_fr = 0; exp_iv = 0; exp_ov = 0; idx = 0; term = 0;
    tmp = part;
    if (!flush && cur.size() == 0) exp_fr = 1;
    if (!flush && cur.size() != 0) begin
      while (idx < cur.size() && tmp.size() < LANES && !term) begin
        tmp.push_back(cur[idx]);
        term = !cur[idx][0];
        idx++;
      end
      if (term) exp_iv = 1;
      else if (tmp.size() == LANES) begin exp_iv = 1; exp_ov = 1; end
    end
    chk(flush ? "R9" : "R2", "fetch_ready", PW'(fetch_ready), PW'(exp_fr));
    chk(flush ? "R9" : "R5", "issue_valid", PW'(issue_valid), PW'(exp_iv));
    if (exp_iv) begin
      exp_w = '0;
      foreach (tmp[i]) exp_w[i*IW +: IW] = tmp[i];
      tag = exp_ov ? "R7" : (part.size() != 0 ? "R6" : "R3");
      chk(tag, "issue_mask", PW'(issue_mask), PW'((1 << tmp.size()) - 1));
      chk(prev_stall ? "R8" : "R4", "issue_words", issue_words, exp_w);
      chk("R7", "issue_overlen", PW'(issue_overlen), PW'(exp_ov));
    end
    prev_stall = exp_iv && !issue_ready;
    // advance the model to the state after this edge
    if (flush) begin
      cur.delete();
      part.delete();
    end else if (cur.size() == 0) begin
      if (fetch_valid) begin
        for (int k = 0; k < LANES; k++) cur.push_back(supply[0][k*IW +: IW]);
        void'(supply.pop_front());
      end
    end else if (exp_iv) begin
      if (issue_ready) begin
        repeat (idx) void'(cur.pop_front());
        part.delete();
      end
    end else begin
      part = tmp;
      cur.delete();
    end
  endtask

  task automatic drain(input int limit);
    for (int n = 0; n < limit; n++) begin
      if (supply.size() == 0 && cur.size() == 0 && part.size() == 0) break;
      step_cycle();
    end
    step_cycle();
  endtask

  initial begin
    rst_n = 0; flush = 0; fetch_valid = 0; issue_ready = 0; fetch_data = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "fetch_ready in reset", PW'(fetch_ready), PW'(1));
    chk("R1", "issue_valid in reset", PW'(issue_valid), PW'(0));
    @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1", "fetch_ready after reset", PW'(fetch_ready), PW'(1));
    chk("R1", "issue_valid after reset", PW'(issue_valid), PW'(0));

    // R5/R3: single-slot packets back to back
    repeat (3) supply.push_back(make_pkt(8'h00));
    drain(200);
    // R3: one full eight-slot packet, then mixed lengths
    supply.push_back(make_pkt(8'h7F));
    supply.push_back(make_pkt(8'b0101_1010));
    drain(200);
    // R6: tail of two slots merged with the head of the next
    supply.push_back(make_pkt(8'b1100_0000));
    supply.push_back(make_pkt(8'b0000_0010));
    drain(200);
    // R7: whole chained packets cut at eight
    supply.push_back(make_pkt(8'hFF));
    supply.push_back(make_pkt(8'hFF));
    supply.push_back(make_pkt(8'h00));
    drain(200);
    // R6+R7: held tail then cut, leaving a new tail
    supply.push_back(make_pkt(8'b1110_0000));
    supply.push_back(make_pkt(8'hFF));
    supply.push_back(make_pkt(8'h00));
    drain(200);
    // R8: backpressure on the issue port
    rdy_pct = 30;
    for (int n = 0; n < 20; n++) supply.push_back(make_pkt(LANES'($urandom)));
    supply.push_back(make_pkt(8'h00));
    drain(2000);
    // R9 and random mix
    rdy_pct = 70; val_pct = 70; flush_pct = 3;
    for (int n = 0; n < 400; n++) supply.push_back(make_pkt(LANES'($urandom)));
    drain(20000);
    flush_pct = 0; rdy_pct = 100; val_pct = 100;
    supply.push_back(make_pkt(8'h00));
    drain(500);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule